// File: doc/BRIEF.md
# Page Write Buffer Loader

This block gathers one page of write data once a page-program command has been accepted upstream. A one-cycle `start` pulse arms it and samples the width mode. Each later write strobe must carry the next address of the page in strictly rising order. The block keeps a 16-bit-wide page store, exposes it through an indexed read port for the programming engine, and pulses `page_done` when the final location has been filled.

In word mode a page is 128 words. The address offset sits in `wr_addr[7:1]`, and `wr_addr[0]` is the byte-select line, which word mode ignores. In byte mode a page is 256 bytes, with the offset in `wr_addr[7:0]`. The page-select bits above the offset are captured on the first data write. A write whose offset is not the expected one, or whose page bits differ from the captured ones, aborts the load and raises `prog_err`. The error stays high until the next `start`.

Top module: `page_load_seq`

## Requirements
- R1: After reset, `loading`, `page_done` and `prog_err` are all low.
- R2: A `start` pulse raises `loading` on the next cycle, clears `prog_err`, resets the expected offset to 0 and samples `byte_mode` (1 = byte mode, 0 = word mode) for the whole load.
- R3: In word mode, write n (n = 0..127) must carry offset n in `wr_addr[7:1]`. `wr_addr[0]` is ignored, and all 16 bits of `wr_data` are stored at word index n.
- R4: In byte mode, write n (n = 0..255) must carry offset n in `wr_addr[7:0]`. `wr_data[7:0]` goes to word index `wr_addr[7:1]`: to bits [7:0] when `wr_addr[0]`=0 and to bits [15:8] when it is 1. `wr_data[15:8]` is ignored.
- R5: The page bits `wr_addr[AW-1:8]` are captured on the first write. `page_base` then shows them with bits [7:0] zero.
- R6: When the last write of the page is accepted, `page_done` is high for exactly one cycle, in the cycle after that write, and `loading` falls in that same cycle.
- R7: A write whose offset differs from the expected one stores nothing. `prog_err` rises and `loading` falls in the next cycle.
- R8: A write after the first whose page bits differ from the captured ones stores nothing, and raises `prog_err` and drops `loading` as in R7.
- R9: Write strobes while `loading` is low store nothing and do not change `prog_err`.
- R10: A `start` pulse during a load restarts it from offset 0 without raising an error.
- R11: `rd_data` shows the stored word at `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new page load |
| byte_mode | input | 1 | 1 = 256-byte page, 0 = 128-word page; sampled on start |
| wr_stb | input | 1 | Data write strobe |
| wr_addr | input | AW | Byte-granular write address |
| wr_data | input | DW | Write data |
| rd_idx | input | IDX_W | Read word index |
| rd_data | output | DW | Stored word at rd_idx |
| loading | output | 1 | Load in progress |
| page_done | output | 1 | One-cycle pulse when the page is complete |
| prog_err | output | 1 | Sequence or page-select error, held until the next start |
| page_base | output | AW | Captured page address with the offset bits zero |

## Verification
Full word-mode pages with a random `wr_addr[0]` show whether the byte-select line is really ignored. Byte-mode pages with random upper data bits show whether the lanes are steered correctly and the upper byte is masked. Randomly injected wrong offsets and wrong page bits, at random positions with random idle gaps, separate sequence errors from page-select errors. They also show that the store is untouched by a rejected write. A restart partway through a load, and strobes while idle, show that the offset counter and the page store change only during an armed load.

// File: rtl/page_load_seq.sv
module page_load_seq #(
  parameter int AW    = 20,
  parameter int IDX_W = 7,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_mode,
  input  logic             wr_stb,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             loading,
  output logic             page_done,
  output logic             prog_err,
  output logic [AW-1:0]    page_base
);
  localparam int CW    = IDX_W + 1;
  localparam int WORDS = 1 << IDX_W;
  localparam int HW    = DW / 2;

  logic [DW-1:0] mem [WORDS];
  logic [CW-1:0] cnt;
  logic          mode_b;

  wire [CW-1:0]    offs     = mode_b ? wr_addr[CW-1:0] : {1'b0, wr_addr[IDX_W:1]};
  wire [CW-1:0]    last     = mode_b ? {CW{1'b1}} : CW'(WORDS - 1);
  wire             upper_ok = (cnt == '0) || (wr_addr[AW-1:CW] == page_base[AW-1:CW]);
  wire             hit      = loading && wr_stb && !start;
  wire             good     = hit && (offs == cnt) && upper_ok;
  wire             bad      = hit && !good;
  wire [IDX_W-1:0] widx     = mode_b ? cnt[CW-1:1] : cnt[IDX_W-1:0];

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading   <= 1'b0;
      page_done <= 1'b0;
      prog_err  <= 1'b0;
      cnt       <= '0;
      mode_b    <= 1'b0;
      page_base <= '0;
    end else begin
      page_done <= 1'b0;
      if (start) begin
        loading  <= 1'b1;
        prog_err <= 1'b0;
        cnt      <= '0;
        mode_b   <= byte_mode;
      end else if (good) begin
        cnt <= cnt + 1'b1;
        if (cnt == '0) page_base <= {wr_addr[AW-1:CW], {CW{1'b0}}};
        if (cnt == last) begin
          loading   <= 1'b0;
          page_done <= 1'b1;
        end
      end else if (bad) begin
        loading  <= 1'b0;
        prog_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (good) begin
      if (!mode_b)     mem[widx]        <= wr_data;
      else if (cnt[0]) mem[widx][DW-1:HW] <= wr_data[HW-1:0];
      else             mem[widx][HW-1:0]  <= wr_data[HW-1:0];
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done);
  assert_done_ends_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> !loading && !prog_err);
  assert_load_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> (page_done || prog_err));
  assert_err_only_from_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_err) |-> $past(loading));
  assert_idle_err_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!loading && !start) |=> $stable(prog_err));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !wr_stb && !start) |=> $stable(cnt) && loading);
endmodule

// File: tb/page_load_seq_tb.sv
module page_load_seq_tb_top;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0, start = 0, byte_mode = 0, wr_stb = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [6:0] rd_idx = '0;
  logic loading, page_done, prog_err;
  logic [AW-1:0] page_base;
  logic [15:0] exp_mem [128];
  int checks = 0, errors = 0;
  bit done_run = 0;

  page_load_seq #(.AW(AW), .IDX_W(7), .DW(16)) dut_i (
    .clk, .rst_n, .start, .byte_mode, .wr_stb, .wr_addr, .wr_data,
    .rd_idx, .rd_data, .loading, .page_done, .prog_err, .page_base);

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(bit bm, logic [11:0] page, int off, bit b0);
    return bm ? {page, 8'(off)} : {page, 7'(off), b0};
  endfunction

  task automatic do_start(bit bm);
    @(negedge clk); start = 1; byte_mode = bm;
    @(negedge clk); start = 0;
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); wr_stb = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_stb = 0;
  endtask

  function automatic void model_store(bit bm, int off, logic [15:0] d);
    if (!bm) exp_mem[off] = d;
    else if (off % 2) exp_mem[off/2][15:8] = d[7:0];
    else exp_mem[off/2][7:0] = d[7:0];
  endfunction

  task automatic check_store(string req);
    for (int i = 0; i < 128; i++) begin
      rd_idx = 7'(i); #1;
      chk(rd_data === exp_mem[i], req, $sformatf("word %0d", i), rd_data, exp_mem[i]);
    end
  endtask

  // load a page; err_pos == len means no fault; kind 0 = offset fault, 1 = page fault
  task automatic load_page(bit bm, logic [11:0] page, int err_pos, int kind, bit gaps);
    int len = bm ? 256 : 128;
    logic [15:0] d;
    do_start(bm);
    chk(loading === 1'b1 && prog_err === 1'b0, "R2", "armed", {loading, prog_err}, 2'b10);
    for (int i = 0; i < len; i++) begin
      d = 16'($urandom);
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      if (i == err_pos) begin
        if (kind == 1 && i > 0)
          do_write(mk_addr(bm, page ^ 12'h1, i, 1'($urandom)), d);
        else
          do_write(mk_addr(bm, page, (i + 1 + $urandom % (len - 1)) % len, 1'($urandom)), d);
        chk(prog_err === 1'b1 && loading === 1'b0 && page_done === 1'b0,
            (kind == 1 && i > 0) ? "R8" : "R7", "fault", {prog_err, loading, page_done}, 3'b100);
        break;
      end
      do_write(mk_addr(bm, page, i, 1'($urandom)), d);
      model_store(bm, i, d);
      if (i == len - 1) begin
        chk(page_done === 1'b1 && loading === 1'b0 && prog_err === 1'b0, "R6", "done",
            {page_done, loading, prog_err}, 3'b100);
        chk(page_base === {page, 8'h00}, "R5", "page_base", page_base, {page, 8'h00});
        @(negedge clk);
        chk(page_done === 1'b0, "R6", "single pulse", page_done, 0);
      end else if (i == 0 || i == len / 2) begin
        chk(loading === 1'b1 && page_done === 1'b0, bm ? "R4" : "R3", "mid load",
            {loading, page_done}, 2'b10);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(loading === 0 && page_done === 0 && prog_err === 0, "R1", "reset outputs",
        {loading, page_done, prog_err}, 0);
    rst_n = 1;
    // R3: full word page, R11 readback
    load_page(0, 12'h0A5, 128, 0, 0);
    check_store("R11");
    // R9: idle strobes ignored
    do_write(mk_addr(0, 12'h0A5, 0, 0), ~exp_mem[0]);
    chk(prog_err === 0 && loading === 0, "R9", "idle strobe", {prog_err, loading}, 0);
    rd_idx = 0; #1;
    chk(rd_data === exp_mem[0], "R9", "idle no store", rd_data, exp_mem[0]);
    // R4: byte page
    load_page(1, 12'h3C2, 256, 0, 1);
    check_store("R4");
    // R7 / R8 directed faults
    load_page(0, 12'h011, 5, 0, 0);
    check_store("R7");
    load_page(1, 12'h022, 9, 1, 0);
    check_store("R8");
    do_write(mk_addr(1, 12'h022, 9, 0), 16'h00FF);
    chk(prog_err === 1, "R9", "error held while idle", prog_err, 1);
    // R10: restart mid-load
    do_start(0);
    for (int i = 0; i < 5; i++) do_write(mk_addr(0, 12'h077, i, 0), 16'hDEAD);
    load_page(0, 12'h078, 128, 0, 0);
    check_store("R10");
    // random mix
    for (int n = 0; n < 12; n++) begin
      bit bm = 1'($urandom);
      int len = bm ? 256 : 128;
      int ep = ($urandom % 3 == 0) ? int'($urandom % len) : len;
      load_page(bm, 12'($urandom), ep, int'($urandom % 2), 1);
      check_store(bm ? "R4" : "R3");
    end
    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule